// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Detection

This block turns an asynchronous serial line into parallel characters. The bit timing comes from a one-cycle sampling enable that pulses 16 times per bit period. The block watches for a falling edge and confirms it half a bit later. It then samples each data bit, an optional parity bit and the first stop bit at mid-bit. The finished character is presented with a one-clock valid strobe. Parity, framing and break flags come with each character.

The character length (5 to 8 bits) and the parity mode (none, even or odd) are set by static configuration inputs. These must stay stable while a character is on the line. A loopback select replaces the external line with an internal serial source for self-test. Baud enable generation, character buffering and any register interface sit outside this block.

Top module: `async_rx`

## Requirements
- R1: After synchronous reset, rx_valid, rx_data, rx_par_err, rx_frm_err and rx_brk are all zero and the receiver is idle.
- R2: cfg_len selects the character length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Bits arrive least significant first. rx_data bits at and above the character length are zero.
- R3: A low level seen on a sampling tick starts a start-bit check. If the line is high again on the 8th tick after that, no character is produced and the receiver returns to idle.
- R4: After a start bit is confirmed, each later bit is sampled once every 16 ticks of tick16. The clock alone does not advance the timing.
- R5: When cfg_par_en is 1, one parity bit follows the data. cfg_par_odd=0 selects even parity and cfg_par_odd=1 selects odd parity. rx_par_err is 1 when the data bits and the parity bit together have the wrong number of ones. When cfg_par_en is 0, rx_par_err is always 0.
- R6: rx_frm_err is 1 when the first stop bit is sampled low. Only the first stop bit is examined, so a new start bit may directly follow one stop bit.
- R7: rx_brk is 1 when every sampled data, parity and stop position is low. A break character also carries rx_frm_err=1 and rx_data=0. Afterwards, no new start bit is accepted until the line has been sampled high.
- R8: rx_valid is high for exactly one clock per character. rx_data and the three flags change only when rx_valid is high and hold their values between strobes.
- R9: With loop_en=1 the receiver takes its input from loop_txd and rxd has no effect. With loop_en=0 it uses rxd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | Sampling enable, 16 pulses per bit |
| rxd | input | 1 | External serial line, idle high |
| loop_en | input | 1 | Selects loop_txd as the serial source |
| loop_txd | input | 1 | Internal serial source for loopback |
| cfg_len | input | 2 | Character length code (0..3 means 5..8 bits) |
| cfg_par_en | input | 1 | Parity bit present and checked |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| rx_valid | output | 1 | One-clock strobe for a new character |
| rx_data | output | 8 | Received character, zero-extended |
| rx_par_err | output | 1 | Parity error for this character |
| rx_frm_err | output | 1 | Framing error for this character |
| rx_brk | output | 1 | Break detected for this character |

## Verification
Break, framing error and parity error can all be reported on the same strobe. The bench provokes this by holding the line low for a whole frame with parity enabled. With odd parity it expects all three flags together. With even parity it expects break and framing error but no parity error, because an all-zero frame has correct even parity. It then keeps the line low past the frame and expects no second character until the line has been high again. It also checks that a start bit sent right after a single stop bit is still taken.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_PAR,
    S_STOP,
    S_HOLD
  } rx_state_e;

  localparam int MIN_LEN = 5;
endpackage

// File: rtl/rx_line_cond.sv
module rx_line_cond #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rxd,
  input  logic loop_en,
  input  logic loop_txd,
  output logic line
);
  logic src;
  logic [SYNC_STAGES-1:0] chain;

  assign src = loop_en ? loop_txd : rxd;

  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= 1'b1;
        else if (g == 0) chain[g] <= src;
        else chain[g] <= chain[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign line = chain[SYNC_STAGES-1];
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import async_rx_pkg::*;
#(
  parameter int OSR    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              line,
  input  logic [1:0]        cfg_len,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  output logic              done,
  output logic [DATA_W-1:0] d_out,
  output logic              pe,
  output logic              fe,
  output logic              bi
);
  localparam int CW   = $clog2(OSR);
  localparam int IW   = $clog2(DATA_W);
  localparam logic [CW-1:0] HALF = CW'(OSR/2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  rx_state_e         state;
  logic [CW-1:0]     cnt;
  logic [IW-1:0]     idx;
  logic [DATA_W-1:0] sh;
  logic              par_acc;
  logic              any_one;
  logic [IW-1:0]     last_idx;
  logic [IW-1:0]     sft;
  logic              all_low;

  assign last_idx = IW'(MIN_LEN - 1) + IW'(cfg_len);
  assign sft      = IW'(DATA_W - 1) - last_idx;
  assign all_low  = ~(any_one | line);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      cnt     <= '0;
      idx     <= '0;
      sh      <= '0;
      par_acc <= 1'b0;
      any_one <= 1'b0;
      done    <= 1'b0;
      d_out   <= '0;
      pe      <= 1'b0;
      fe      <= 1'b0;
      bi      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        case (state)
          S_IDLE: begin
            if (!line) begin
              state <= S_START;
              cnt   <= '0;
            end
          end
          S_START: begin
            if (cnt == HALF) begin
              cnt <= '0;
              if (line) begin
                state <= S_IDLE;
              end else begin
                state   <= S_DATA;
                idx     <= '0;
                sh      <= '0;
                par_acc <= 1'b0;
                any_one <= 1'b0;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_DATA: begin
            if (cnt == LAST) begin
              cnt     <= '0;
              sh      <= {line, sh[DATA_W-1:1]};
              par_acc <= par_acc ^ line;
              any_one <= any_one | line;
              if (idx == last_idx) state <= cfg_par_en ? S_PAR : S_STOP;
              else idx <= idx + 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_PAR: begin
            if (cnt == LAST) begin
              cnt     <= '0;
              par_acc <= par_acc ^ line;
              any_one <= any_one | line;
              state   <= S_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_STOP: begin
            if (cnt == LAST) begin
              cnt   <= '0;
              done  <= 1'b1;
              d_out <= sh >> sft;
              pe    <= cfg_par_en & (par_acc ^ cfg_par_odd);
              fe    <= ~line;
              bi    <= all_low;
              state <= all_low ? S_HOLD : S_IDLE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_HOLD: begin
            if (line) state <= S_IDLE;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  // R3: a start that is high again at the confirmation tick goes back to idle
  p_false_start_r3: assert property (@(posedge clk) disable iff (rst)
    (state == S_START && tick && cnt == HALF && line) |=> state == S_IDLE);

  // R7: after a break, a low line keeps the receiver parked
  p_break_park_r7: assert property (@(posedge clk) disable iff (rst)
    (state == S_HOLD && !line) |=> state == S_HOLD);

  // R4: without a tick the bit timing counter does not move
  p_tick_gate_r4: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt));
endmodule

// File: rtl/async_rx.sv
module async_rx
  import async_rx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick16,
  input  logic              rxd,
  input  logic              loop_en,
  input  logic              loop_txd,
  input  logic [1:0]        cfg_len,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_par_err,
  output logic              rx_frm_err,
  output logic              rx_brk
);
  logic line;

  rx_line_cond #(.SYNC_STAGES(SYNC_STAGES)) u_line (
    .clk      (clk),
    .rst      (rst),
    .rxd      (rxd),
    .loop_en  (loop_en),
    .loop_txd (loop_txd),
    .line     (line)
  );

  rx_frame_fsm #(.OSR(OSR), .DATA_W(DATA_W)) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick16),
    .line        (line),
    .cfg_len     (cfg_len),
    .cfg_par_en  (cfg_par_en),
    .cfg_par_odd (cfg_par_odd),
    .done        (rx_valid),
    .d_out       (rx_data),
    .pe          (rx_par_err),
    .fe          (rx_frm_err),
    .bi          (rx_brk)
  );

  // R8: strobe lasts a single clock
  p_valid_single_r8: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  // R8: character and flags hold between strobes
  p_hold_outputs_r8: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |-> ($stable(rx_data) && $stable(rx_brk) && $stable(rx_frm_err)));

  // R7: a break also reports a framing error and an all-zero character
  p_break_frame_r7: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_brk) |-> (rx_frm_err && rx_data == '0));

  // R2: a 5-bit character leaves the upper bits clear
  p_upper_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && cfg_len == 2'd0) |-> rx_data[DATA_W-1:MIN_LEN] == '0);

  // R5: no parity error without parity
  p_parity_off_r5: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !cfg_par_en) |-> !rx_par_err);
endmodule

// File: tb/async_rx_tb.sv
module async_rx_tb;
  typedef struct packed {
    logic [7:0] data;
    logic       pe;
    logic       fe;
    logic       bi;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick16 = 1'b0;
  logic       rxd = 1'b1;
  logic       loop_en = 1'b0;
  logic       loop_txd = 1'b1;
  logic [1:0] cfg_len = 2'd3;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_odd = 1'b0;
  logic       rx_valid;
  logic [7:0] rx_data;
  logic       rx_par_err, rx_frm_err, rx_brk;

  int   checks = 0;
  int   errors = 0;
  bit   finished = 1'b0;
  exp_t q[$];
  string tagq[$];

  always #2.5 clk = ~clk;

  async_rx u_dut (
    .clk(clk), .rst(rst), .tick16(tick16), .rxd(rxd),
    .loop_en(loop_en), .loop_txd(loop_txd), .cfg_len(cfg_len),
    .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_par_err(rx_par_err),
    .rx_frm_err(rx_frm_err), .rx_brk(rx_brk)
  );

  // one tick every 4 clocks: one bit is 64 clocks
  initial begin
    @(negedge clk);
    forever begin
      tick16 = 1'b1;
      @(negedge clk);
      tick16 = 1'b0;
      repeat (3) @(negedge clk);
    end
  end

  task automatic check(input bit ok, input string tag, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  task automatic drive_bit(input logic b, input int nbits);
    if (loop_en) loop_txd = b; else rxd = b;
    repeat (64 * nbits) @(negedge clk);
  endtask

  // driver: computes the expectation from the requirements, then sends
  task automatic send_frame(input logic [7:0] d, input bit flip_par,
                            input logic stop_bit, input int idle_bits,
                            input string tag);
    int   len;
    logic [7:0] m;
    logic p;
    exp_t e;
    len = 5 + int'(cfg_len);
    m = d & 8'((1 << len) - 1);
    p = (^m) ^ cfg_par_odd ^ flip_par;
    e.data = m;
    e.pe   = cfg_par_en & flip_par;
    e.fe   = ~stop_bit;
    e.bi   = (m == 8'd0) && (!cfg_par_en || p == 1'b0) && !stop_bit;
    q.push_back(e);
    tagq.push_back(tag);
    drive_bit(1'b0, 1);
    for (int i = 0; i < len; i++) drive_bit(m[i], 1);
    if (cfg_par_en) drive_bit(p, 1);
    drive_bit(stop_bit, 1);
    if (idle_bits > 0) drive_bit(1'b1, idle_bits);
  endtask

  // monitor: pops and compares on every strobe
  always @(negedge clk) begin
    if (!rst && rx_valid) begin
      if (q.size() == 0) begin
        check(1'b0, "R3", $sformatf("unexpected character act=%h exp=none", rx_data));
      end else begin
        exp_t e;
        string t;
        e = q.pop_front();
        t = tagq.pop_front();
        check({rx_data, rx_par_err, rx_frm_err, rx_brk} == e, t,
              $sformatf("act data=%h pe=%0b fe=%0b bi=%0b exp data=%h pe=%0b fe=%0b bi=%0b",
                        rx_data, rx_par_err, rx_frm_err, rx_brk,
                        e.data, e.pe, e.fe, e.bi));
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R1", "watchdog expired act=running exp=done");
    summary();
  end

  initial begin
    logic [7:0] last;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check({rx_valid, rx_data, rx_par_err, rx_frm_err, rx_brk} == 12'd0, "R1",
          $sformatf("act=%h exp=000", {rx_valid, rx_data, rx_par_err, rx_frm_err, rx_brk}));
    drive_bit(1'b1, 2);

    // R2 R4 lengths, no parity, LSB first
    cfg_len = 2'd3; send_frame(8'hA5, 0, 1'b1, 1, "R2_len8");
    cfg_len = 2'd2; send_frame(8'hFF, 0, 1'b1, 1, "R2_len7");
    cfg_len = 2'd1; send_frame(8'h2D, 0, 1'b1, 1, "R2_len6");
    cfg_len = 2'd0; send_frame(8'hF3, 0, 1'b1, 1, "R2_len5");

    // R5 parity modes, good and bad
    cfg_len = 2'd3; cfg_par_en = 1'b1;
    cfg_par_odd = 1'b0; send_frame(8'h37, 0, 1'b1, 1, "R5_even_ok");
    cfg_par_odd = 1'b0; send_frame(8'h37, 1, 1'b1, 1, "R5_even_bad");
    cfg_par_odd = 1'b1; send_frame(8'h81, 0, 1'b1, 1, "R5_odd_ok");
    cfg_par_odd = 1'b1; send_frame(8'h00, 1, 1'b1, 1, "R5_odd_bad");

    // R6 framing error, then back-to-back with single stop bit
    cfg_par_en = 1'b0;
    send_frame(8'h5A, 0, 1'b0, 1, "R6_frame");
    send_frame(8'h11, 0, 1'b1, 0, "R6_b2b_a");
    send_frame(8'hEE, 0, 1'b1, 1, "R6_b2b_b");

    // R3 false start: low for 3 ticks only
    rxd = 1'b0; repeat (12) @(negedge clk);
    rxd = 1'b1; drive_bit(1'b1, 2);
    check(q.size() == 0, "R3", $sformatf("pending act=%0d exp=0", q.size()));
    send_frame(8'h3C, 0, 1'b1, 1, "R3_after_glitch");

    // R7 break with odd parity: all three flags; line kept low for long
    cfg_par_en = 1'b1; cfg_par_odd = 1'b1;
    send_frame(8'h00, 1, 1'b0, 0, "R7_break_odd");
    drive_bit(1'b0, 12);
    drive_bit(1'b1, 2);
    check(q.size() == 0, "R7", $sformatf("pending act=%0d exp=0", q.size()));
    // R7 break with even parity: no parity error
    cfg_par_odd = 1'b0;
    send_frame(8'h00, 0, 1'b0, 0, "R7_break_even");
    drive_bit(1'b0, 3);
    drive_bit(1'b1, 2);
    send_frame(8'hC4, 0, 1'b1, 1, "R7_after_break");
    cfg_par_en = 1'b0;

    // R8 outputs hold between strobes
    last = rx_data;
    drive_bit(1'b1, 3);
    check(rx_data == last && !rx_valid, "R8",
          $sformatf("act=%h exp=%h", rx_data, last));

    // R9 loopback: rxd held low must not matter
    rxd = 1'b0; loop_en = 1'b1; loop_txd = 1'b1;
    drive_bit(1'b1, 2);
    send_frame(8'h96, 0, 1'b1, 1, "R9_loop");
    loop_en = 1'b0; rxd = 1'b1;
    drive_bit(1'b1, 2);
    // R4 sampling follows tick: 8-bit char still decoded after a stall-free gap
    send_frame(8'h69, 0, 1'b1, 1, "R4_timing");

    repeat (200) @(negedge clk);
    check(q.size() == 0, "R8", $sformatf("missing strobes act=%0d exp=0", q.size()));
    summary();
  end
endmodule